// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of timer channels. It takes each channel's fire strobe and turns it into an interrupt. The interrupt can go out on one of 32 interrupt lines, or it can go out as a single message-write request. Each channel supplies the following settings:

- an enable;
- a trigger type, level or edge;
- a 5-bit line selector;
- a message-delivery enable;
- a 64-bit message word.

The block keeps one status bit per channel. Software clears these bits by writing ones.

A legacy-replacement mode overrides the line choice for the two lowest channels. In the same mode the block blocks the external periodic-tick input and the real-time-clock input from reaching their lines, and it drops an enable output for the external periodic-tick source. Outside that mode, the two external inputs pass straight to their lines. The latest real-time-clock level is always captured, so line 8 picks it up again as soon as the mode is left.

Every output is registered. A change seen on the inputs at one rising clock edge appears on the outputs right after that edge.

Top module: `tmr_irq_router`

## Requirements
- R1: After a synchronous active-low reset, all of the following hold:
  - every status bit is 0;
  - no line is asserted, so `irq_o` reads 0xFFFF0000;
  - `pit_enable_o` is 1;
  - `msg_req_o` is 0.
- R2: A level-type channel that fires while live sets its status bit on the next edge. Live means the channel enable and the global enable are both 1, and message delivery is off. The bit holds its line asserted until it is cleared.
- R3: An edge-type live channel that fires asserts its line for exactly one cycle and leaves its status bit at 0.
- R4: A status write clears each status bit whose written bit is 1. Written 0s, and 1s on bits already clear, change nothing. A fire in the same cycle takes precedence over the clear.
- R5: While a channel's enable or the global enable is 0, its status bit is held at 0 and it drives no line. A fire in that state is ignored.
- R6: A live channel with message delivery on produces the following on its fire:
  - a one-cycle `msg_req_o`;
  - an address equal to bits [63:32] of its message word, and data equal to bits [31:0];
  - no line activity, and its status bit stays 0.
  
  When several such channels fire together, the lowest-numbered one wins. Turning message delivery on clears a pending status bit.
- R7: Lines 16 to 31 are active low. Lines 0 to 15 are active high.
- R8: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8, whatever their selectors hold. Other channels keep their selectors.
- R9: In legacy mode, `pit_enable_o` is 0 and the external tick and clock inputs do not reach lines 0 and 8.
- R10: Outside legacy mode, the external tick input drives line 0 and the stored clock level drives line 8. The clock level is captured every cycle, in either mode.
- R11: The 5-bit selector picks the line, values 0 to 31. All sources aimed at one line are ORed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy-replacement mode |
| ch_fire_i | input | NUM_CH | Per-channel fire strobe |
| ch_en_i | input | NUM_CH | Per-channel enable |
| ch_level_i | input | NUM_CH | 1 = level type, 0 = edge type |
| ch_msg_en_i | input | NUM_CH | Per-channel message-delivery enable |
| ch_route_i | input | NUM_CH*5 | Line selector, channel c at bits [5c+4:5c] |
| ch_msg_word_i | input | NUM_CH*64 | Message word; address in upper half, data in lower half |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | NUM_CH | Status write data, 1 clears |
| pit_in_i | input | 1 | External periodic-tick interrupt level |
| rtc_in_i | input | 1 | External real-time-clock interrupt level |
| irq_o | output | 32 | Interrupt lines, polarity per R7 |
| sts_o | output | NUM_CH | Per-channel status bits |
| pit_enable_o | output | 1 | Enable for the external tick source |
| msg_req_o | output | 1 | One-cycle message write request |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The hardest situation to reach is a collision on one clock edge. Examples are a status clear landing on the same edge as a fire, or legacy mode being toggled while the clock input changes level. Either can mask a wrong priority or a stale stored level.

The bench sweeps every channel across all 32 selector values in both trigger types. It then steps through directed sequences that line up fire, clear, disable, message enable and mode changes on the same edge. A cycle-accurate model written from the requirements is compared on every cycle.

// File: rtl/tmr_irq_pkg.sv
// Package: shared constants and helpers for the timer interrupt router.
// Assumes a 5-bit line selector, giving 32 interrupt lines.
package tmr_irq_pkg;
    localparam int ROUTE_W     = 5;
    localparam int NUM_LINES   = 1 << ROUTE_W;
    localparam int LOW_ACT_MIN = 16;
    localparam logic [ROUTE_W-1:0] LEG_TICK_LINE  = 5'd0;
    localparam logic [ROUTE_W-1:0] LEG_CLOCK_LINE = 5'd8;

    // Polarity mask: a 1 marks an active-low line.
    function automatic logic [NUM_LINES-1:0] low_active_mask();
        logic [NUM_LINES-1:0] m;
        for (int l = 0; l < NUM_LINES; l++) begin
            m[l] = (l >= LOW_ACT_MIN);
        end
        return m;
    endfunction
endpackage

// File: rtl/tmr_irq_chan.sv
// Module: per-channel status and pulse state.
// Holds the status bit (level type) and a one-cycle pulse flag (edge type).
// Assumes the fire input is a single-cycle strobe.
module tmr_irq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic en_i,
    input  logic glb_en_i,
    input  logic level_i,
    input  logic msg_en_i,
    input  logic clr_i,
    output logic sts_o,
    output logic drive_o,
    output logic msg_fire_o
);
    logic live;
    logic sts_q;
    logic pulse_q;

    assign live = en_i & glb_en_i;

    // Status and pulse update; disable or message mode forces status clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= live & fire_i & ~level_i & ~msg_en_i;
            if (!live || msg_en_i) begin
                sts_q <= 1'b0;
            end else if (fire_i) begin
                sts_q <= level_i;
            end else if (clr_i) begin
                sts_q <= 1'b0;
            end
        end
    end

    assign sts_o      = sts_q;
    assign drive_o    = sts_q | pulse_q;
    assign msg_fire_o = live & fire_i & msg_en_i;
endmodule

// File: rtl/tmr_irq_merge.sv
// Module: line merge and polarity stage.
// ORs every channel drive onto its selected line and adds the external
// sources when legacy mode is off. It then applies per-line polarity.
// Assumes all inputs come from registers, so the output is glitch-safe.
module tmr_irq_merge #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0]                       drive_i,
    input  logic [NUM_CH*tmr_irq_pkg::ROUTE_W-1:0]  route_i,
    input  logic                                    legacy_i,
    input  logic                                    tick_i,
    input  logic                                    clock_i,
    output logic [tmr_irq_pkg::NUM_LINES-1:0]       irq_o
);
    import tmr_irq_pkg::*;

    localparam logic [NUM_LINES-1:0] POL_MASK = low_active_mask();

    logic [NUM_LINES-1:0] act;

    // Logical line activity from channels and gated external inputs.
    always_comb begin
        act = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (drive_i[c]) begin
                act[route_i[c*ROUTE_W +: ROUTE_W]] = 1'b1;
            end
        end
        if (!legacy_i) begin
            act[LEG_TICK_LINE]  = act[LEG_TICK_LINE]  | tick_i;
            act[LEG_CLOCK_LINE] = act[LEG_CLOCK_LINE] | clock_i;
        end
    end

    genvar gl;
    generate
        for (gl = 0; gl < NUM_LINES; gl++) begin : g_pol
            if (POL_MASK[gl]) begin : g_low
                assign irq_o[gl] = ~act[gl];
            end else begin : g_high
                assign irq_o[gl] = act[gl];
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_irq_msg_pick.sv
// Module: message request selector.
// Picks the lowest-numbered channel with a message fire. It registers a
// one-cycle request carrying that channel's address and data.
// Assumes address in the upper half of each word, data in the lower half.
module tmr_irq_msg_pick #(
    parameter int NUM_CH = 4,
    parameter int AW     = 32,
    parameter int DW     = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      fire_i,
    input  logic [NUM_CH*(AW+DW)-1:0] word_i,
    output logic                   req_o,
    output logic [AW-1:0]          addr_o,
    output logic [DW-1:0]          data_o
);
    localparam int WW = AW + DW;

    logic [WW-1:0] sel_word;

    // Priority select: scan downward so the lowest index wins.
    always_comb begin
        sel_word = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (fire_i[c]) begin
                sel_word = word_i[c*WW +: WW];
            end
        end
    end

    // Request register; address and data hold between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
        end else begin
            req_o <= |fire_i;
            if (|fire_i) begin
                addr_o <= sel_word[WW-1:DW];
                data_o <= sel_word[DW-1:0];
            end
        end
    end
endmodule

// File: rtl/tmr_irq_router.sv
// Module: timer interrupt router top.
// Registers mode, external levels and selectors, and runs one state slice
// per channel. Outputs are merged onto 32 lines plus a message request.
// Assumes all inputs are synchronous to clk.
module tmr_irq_router #(
    parameter int NUM_CH = 4,
    parameter int MSG_AW = 32,
    parameter int MSG_DW = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            glb_en_i,
    input  logic                            legacy_i,
    input  logic [NUM_CH-1:0]               ch_fire_i,
    input  logic [NUM_CH-1:0]               ch_en_i,
    input  logic [NUM_CH-1:0]               ch_level_i,
    input  logic [NUM_CH-1:0]               ch_msg_en_i,
    input  logic [NUM_CH*5-1:0]             ch_route_i,
    input  logic [NUM_CH*(MSG_AW+MSG_DW)-1:0] ch_msg_word_i,
    input  logic                            sts_wr_i,
    input  logic [NUM_CH-1:0]               sts_wdata_i,
    input  logic                            pit_in_i,
    input  logic                            rtc_in_i,
    output logic [31:0]                     irq_o,
    output logic [NUM_CH-1:0]               sts_o,
    output logic                            pit_enable_o,
    output logic                            msg_req_o,
    output logic [MSG_AW-1:0]               msg_addr_o,
    output logic [MSG_DW-1:0]               msg_data_o
);
    import tmr_irq_pkg::*;

    logic                      leg_q;
    logic                      tick_q;
    logic                      clock_q;
    logic [NUM_CH-1:0]         drive;
    logic [NUM_CH-1:0]         msg_fire;
    logic [NUM_CH*ROUTE_W-1:0] eff_route;

    // Mode and external level capture; clock level is stored in any mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leg_q   <= 1'b0;
            tick_q  <= 1'b0;
            clock_q <= 1'b0;
        end else begin
            leg_q   <= legacy_i;
            tick_q  <= pit_in_i;
            clock_q <= rtc_in_i;
        end
    end

    assign pit_enable_o = ~leg_q;

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
            logic [ROUTE_W-1:0] rt_q;

            // Selector register so line choice follows the same latency.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rt_q <= '0;
                end else begin
                    rt_q <= ch_route_i[gc*ROUTE_W +: ROUTE_W];
                end
            end

            if (gc == 0) begin : g_leg0
                assign eff_route[gc*ROUTE_W +: ROUTE_W] = leg_q ? LEG_TICK_LINE : rt_q;
            end else if (gc == 1) begin : g_leg1
                assign eff_route[gc*ROUTE_W +: ROUTE_W] = leg_q ? LEG_CLOCK_LINE : rt_q;
            end else begin : g_norm
                assign eff_route[gc*ROUTE_W +: ROUTE_W] = rt_q;
            end

            tmr_irq_chan u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .fire_i     (ch_fire_i[gc]),
                .en_i       (ch_en_i[gc]),
                .glb_en_i   (glb_en_i),
                .level_i    (ch_level_i[gc]),
                .msg_en_i   (ch_msg_en_i[gc]),
                .clr_i      (sts_wr_i & sts_wdata_i[gc]),
                .sts_o      (sts_o[gc]),
                .drive_o    (drive[gc]),
                .msg_fire_o (msg_fire[gc])
            );
        end
    endgenerate

    tmr_irq_merge #(.NUM_CH(NUM_CH)) u_merge (
        .drive_i  (drive),
        .route_i  (eff_route),
        .legacy_i (leg_q),
        .tick_i   (tick_q),
        .clock_i  (clock_q),
        .irq_o    (irq_o)
    );

    tmr_irq_msg_pick #(.NUM_CH(NUM_CH), .AW(MSG_AW), .DW(MSG_DW)) u_msg (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (msg_fire),
        .word_i (ch_msg_word_i),
        .req_o  (msg_req_o),
        .addr_o (msg_addr_o),
        .data_o (msg_data_o)
    );
endmodule

// File: rtl/tmr_irq_router_chk.sv
// Module: property checker for the timer interrupt router, bound to the top.
// Assumes port names of the top module.
module tmr_irq_router_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glb_en_i,
    input logic              legacy_i,
    input logic [NUM_CH-1:0] ch_fire_i,
    input logic [NUM_CH-1:0] ch_en_i,
    input logic [NUM_CH-1:0] ch_level_i,
    input logic [NUM_CH-1:0] ch_msg_en_i,
    input logic              sts_wr_i,
    input logic [NUM_CH-1:0] sts_wdata_i,
    input logic [NUM_CH-1:0] sts_o,
    input logic              pit_enable_o,
    input logic              msg_req_o
);
    logic [NUM_CH-1:0] msg_live_fire;
    assign msg_live_fire = ch_fire_i & ch_en_i & ch_msg_en_i & {NUM_CH{glb_en_i}};

    p_legacy_pit_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_i |=> !pit_enable_o);
    p_normal_pit_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_i |=> pit_enable_o);
    p_msg_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_live_fire == '0) |=> !msg_req_o);

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_p
            p_level_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_fire_i[gc] && ch_en_i[gc] && glb_en_i && ch_level_i[gc] && !ch_msg_en_i[gc])
                |=> sts_o[gc]);
            p_edge_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_fire_i[gc] && ch_en_i[gc] && glb_en_i && !ch_level_i[gc])
                |=> !sts_o[gc]);
            p_write_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (sts_wr_i && sts_wdata_i[gc] && !ch_fire_i[gc])
                |=> !sts_o[gc]);
            p_off_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!ch_en_i[gc] || !glb_en_i) |=> !sts_o[gc]);
            p_msg_no_sts_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ch_msg_en_i[gc] |=> !sts_o[gc]);
        end
    endgenerate
endmodule

bind tmr_irq_router tmr_irq_router_chk #(.NUM_CH(NUM_CH)) chk_i (.*);

// File: tb/tmr_irq_router_tb_top.sv
// Bench: cycle model written from the requirements, compared every cycle.
`timescale 1ns/1ps
module tmr_irq_router_tb_top;
    localparam int NCH = 4;
    localparam int WW  = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              glb_en, legacy;
    logic [NCH-1:0]    fire, en, lvl, msg_en;
    logic [NCH*5-1:0]  route;
    logic [NCH*WW-1:0] word;
    logic              sts_wr;
    logic [NCH-1:0]    sts_wd;
    logic              pit_in, rtc_in;
    logic [31:0]       irq;
    logic [NCH-1:0]    sts;
    logic              pit_en;
    logic              mreq;
    logic [31:0]       maddr, mdata;

    always #10 clk = ~clk;

    tmr_irq_router #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en), .legacy_i(legacy),
        .ch_fire_i(fire), .ch_en_i(en), .ch_level_i(lvl), .ch_msg_en_i(msg_en),
        .ch_route_i(route), .ch_msg_word_i(word), .sts_wr_i(sts_wr),
        .sts_wdata_i(sts_wd), .pit_in_i(pit_in), .rtc_in_i(rtc_in),
        .irq_o(irq), .sts_o(sts), .pit_enable_o(pit_en), .msg_req_o(mreq),
        .msg_addr_o(maddr), .msg_data_o(mdata)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string tag    = "R1";

    // Model state.
    logic [NCH-1:0]   m_sts, m_pulse;
    logic             m_leg, m_pit, m_rtc, m_req;
    logic [31:0]      m_addr, m_data;
    logic [NCH*5-1:0] m_rt;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_irq();
        logic [31:0] a = '0;
        for (int c = 0; c < NCH; c++) begin
            int l = m_rt[c*5 +: 5];
            if (m_leg && c == 0) l = 0;
            if (m_leg && c == 1) l = 8;
            if (m_sts[c] | m_pulse[c]) a[l] = 1'b1;
        end
        if (!m_leg) begin
            a[0] = a[0] | m_pit;
            a[8] = a[8] | m_rtc;
        end
        return a ^ 32'hFFFF_0000;
    endfunction

    // Advance model by one edge from current inputs, then compare outputs.
    task automatic tick();
        if (!rst_n) begin
            m_sts = '0; m_pulse = '0; m_leg = 0; m_pit = 0; m_rtc = 0;
            m_req = 0; m_addr = '0; m_data = '0; m_rt = '0;
        end else begin
            m_req = 0;
            for (int c = 0; c < NCH; c++) begin
                logic live = en[c] & glb_en;
                m_pulse[c] = live & fire[c] & ~lvl[c] & ~msg_en[c];
                if (!live || msg_en[c]) m_sts[c] = 1'b0;
                else if (fire[c])       m_sts[c] = lvl[c];
                else if (sts_wr && sts_wd[c]) m_sts[c] = 1'b0;
            end
            for (int c = NCH - 1; c >= 0; c--) begin
                if (fire[c] && en[c] && glb_en && msg_en[c]) begin
                    m_req  = 1;
                    m_addr = word[c*WW+32 +: 32];
                    m_data = word[c*WW +: 32];
                end
            end
            m_leg = legacy; m_pit = pit_in; m_rtc = rtc_in; m_rt = route;
        end
        @(posedge clk);
        @(negedge clk);
        chk("irq_o", {32'd0, irq}, {32'd0, exp_irq()});
        chk("sts_o", {60'd0, sts}, {60'd0, m_sts});
        chk("pit_enable_o", {63'd0, pit_en}, {63'd0, ~m_leg});
        chk("msg_req_o", {63'd0, mreq}, {63'd0, m_req});
        if (m_req) chk("msg addr/data", {maddr, mdata}, {m_addr, m_data});
    endtask

    task automatic set_rt(input int c, input int r);
        route[c*5 +: 5] = r[4:0];
    endtask

    task automatic pulse_fire(input logic [NCH-1:0] f);
        fire = f; tick(); fire = '0;
    endtask

    task automatic clear_sts(input logic [NCH-1:0] m);
        sts_wr = 1; sts_wd = m; tick(); sts_wr = 0; sts_wd = '0;
    endtask

    initial begin
        #3000000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; glb_en = 0; legacy = 0; fire = '0; en = '0; lvl = '0;
        msg_en = '0; route = '0; word = '0; sts_wr = 0; sts_wd = '0;
        pit_in = 0; rtc_in = 0;
        @(negedge clk);
        // R1: reset state.
        tag = "R1";
        tick(); tick();
        rst_n = 1;
        tick();

        glb_en = 1;
        // R11 (level) and R3 (edge): every channel, every selector value.
        for (int t = 0; t < 2; t++) begin
            tag = (t == 0) ? "R11" : "R3";
            for (int c = 0; c < NCH; c++) begin
                for (int r = 0; r < 32; r++) begin
                    en = '0; en[c] = 1; lvl[c] = (t == 0); set_rt(c, r);
                    tick();
                    pulse_fire(4'b1 << c);
                    tick();
                    clear_sts(4'b1 << c);
                    en[c] = 0;
                    tick();
                end
            end
        end

        // R2 and R7: two level channels on high and low lines, held.
        tag = "R2";
        en = 4'b0011; lvl = 4'b0011; set_rt(0, 3); set_rt(1, 20);
        tick();
        pulse_fire(4'b0011);
        tick(); tick();
        tag = "R7";
        set_rt(2, 31); en[2] = 1; lvl[2] = 0;
        tick();
        pulse_fire(4'b0100);
        tick();

        // R11: two channels aimed at one line, then one cleared.
        tag = "R11";
        set_rt(1, 3);
        tick();
        clear_sts(4'b0001);
        tick();

        // R4: clear with zeros and on clear bits, and a fire on the same edge.
        tag = "R4";
        clear_sts(4'b0000);
        clear_sts(4'b1100);
        fire = 4'b0001; sts_wr = 1; sts_wd = 4'b0011;
        tick();
        fire = '0; sts_wr = 0; sts_wd = '0;
        tick();
        clear_sts(4'b1111);

        // R5: channel off, global off, fire while off.
        tag = "R5";
        pulse_fire(4'b0011);
        en[0] = 0; tick();
        glb_en = 0; tick();
        pulse_fire(4'b0011);
        en[0] = 1; glb_en = 1;
        tick();
        pulse_fire(4'b0001);
        glb_en = 0; tick();
        glb_en = 1; tick();

        // R6: message delivery, pending status drop, priority.
        tag = "R6";
        word = {64'hA3A3_0003_D3D3_0003, 64'hA2A2_0002_D2D2_0002,
                64'hA1A1_0001_D1D1_0001, 64'hA0A0_0000_D0D0_0000};
        en = 4'b1111; lvl = 4'b1111;
        pulse_fire(4'b0100);
        msg_en[2] = 1; tick();
        pulse_fire(4'b0100);
        tick();
        msg_en = 4'b1010;
        tick();
        pulse_fire(4'b1010);
        pulse_fire(4'b1000);
        pulse_fire(4'b1111);
        msg_en = '0;
        clear_sts(4'b1111);

        // R8: legacy override of channels 0 and 1.
        tag = "R8";
        set_rt(0, 17); set_rt(1, 25); set_rt(2, 9);
        legacy = 1;
        tick();
        pulse_fire(4'b0001); tick();
        pulse_fire(4'b0010); tick();
        pulse_fire(4'b0100); tick();
        legacy = 0; tick();
        clear_sts(4'b1111);

        // R9: external inputs gated in legacy mode.
        tag = "R9";
        pit_in = 1; rtc_in = 1;
        tick();
        legacy = 1; tick(); tick();
        rtc_in = 0; tick();
        rtc_in = 1; tick();

        // R10: leaving legacy restores the stored clock level, tick passes.
        tag = "R10";
        legacy = 0; tick();
        pit_in = 0; tick();
        rtc_in = 0; tick();
        legacy = 1; rtc_in = 1; tick();
        legacy = 0; tick();
        for (int k = 0; k < 4; k++) begin
            pit_in = k[0]; rtc_in = k[1];
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule